// File: doc/BRIEF.md
# System Clock Speed-Mode Switcher

This block produces the internal system clock `phi_o` from two free-running inputs: a fast main oscillator and a slow sub-clock. It offers four speeds. Double-speed passes the main input straight through. High-speed divides it by 2. Middle-speed divides it by 8. Low-speed takes the sub-clock divided by 2.

Software requests a speed with a single whole-register write. The block first turns off the source that is currently driving the output and waits until that source is confirmed off. It then enables the new source. Every enable changes only while its own source is low, so the output never shows a shortened pulse. While a change is in progress a busy flag is raised. Any further request made during that time is parked and applied once the change has finished.

A direct jump from low-speed to double-speed is refused. The refused request raises a sticky error flag and leaves the mode as it was.

Top module: `clk_mode_switch`

## Requirements
- R1: After reset `mode_o` reads middle-speed, `busy_o` and `err_o` are low, and `phi_o` runs at the middle-speed rate.
- R2: A write with `wr_en_i` high carries the whole register. `wr_data_i[1:0]` is the requested mode, encoded 00 low, 01 middle, 10 high, 11 double. `wr_data_i[2]` set to 1 clears the error flag.
- R3: Once `busy_o` is low, the period of `phi_o` is as follows: 8 main periods in middle, 2 in high, 1 in double, and 2 sub-clock periods in low.
- R4: A request for double-speed made while the mode is low-speed is refused. `mode_o` keeps low, `busy_o` stays low, `phi_o` keeps its rate and `err_o` goes high.
- R5: `err_o` stays high until a write with bit 2 set. A write with bit 2 clear does not clear it.
- R6: An accepted change raises `busy_o`. `busy_o` falls when the new source drives `phi_o`, and `mode_o` takes the new value in that same cycle and at no other time.
- R7: A change that leaves low-speed completes, with `busy_o` back low, no sooner than 1 and no later than 4 low-speed `phi_o` periods after the write.
- R8: A write made while `busy_o` is high is held and applied after the current change. Of several held writes, only the last one takes effect.
- R9: A request for the mode already in force is accepted without action: `busy_o` stays low and `phi_o` continues without interruption.
- R10: At most one source is enabled at any time, and no high or low phase of `phi_o` is shorter than half a main period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Main oscillator; also clocks the register and control logic |
| clk_sub_i | input | 1 | Slow sub-clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 3 | Write data: [1:0] mode request, [2] error clear |
| mode_o | output | 2 | Mode currently in force |
| busy_o | output | 1 | A mode change is in progress |
| err_o | output | 1 | Sticky flag for a refused request |
| phi_o | output | 1 | Internal system clock |

## Verification
The bound checker checks the following on every main-clock cycle:
- At most one source enable is active.
- `mode_o` moves only on the cycle that `busy_o` falls, and it never steps from low to double.
- The error flag holds until it is explicitly cleared.
- When `busy_o` falls, the enable of the new source is already on.
- While idle, the source selection agrees with `mode_o`.

The following can only be shown by the bench's scenarios:
- The actual output periods.
- The absence of short pulses on `phi_o`.
- The 1-to-4 period bound on leaving low-speed.
- The holding of requests that arrive during a change.

The bench sweeps every pair of starting and requested mode to cover these.

// File: rtl/clk_mode_pkg.sv
`timescale 1ns/1ps
package clk_mode_pkg;

  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_MID  = 2'd1,
    MODE_HIGH = 2'd2,
    MODE_DBL  = 2'd3
  } mode_e;

  localparam int unsigned N_SRC   = 3;
  localparam int unsigned SRC_RAW = 0;  // main, undivided
  localparam int unsigned SRC_DIV = 1;  // main, divided
  localparam int unsigned SRC_SUB = 2;  // sub-clock, divided

  function automatic logic [N_SRC-1:0] src_of(mode_e m);
    logic [N_SRC-1:0] s;
    s = '0;
    case (m)
      MODE_LOW: s[SRC_SUB] = 1'b1;
      MODE_DBL: s[SRC_RAW] = 1'b1;
      default:  s[SRC_DIV] = 1'b1;
    endcase
    return s;
  endfunction

  function automatic logic step_refused(mode_e cur, mode_e nxt);
    return (cur == MODE_LOW) && (nxt == MODE_DBL);
  endfunction

endpackage

// File: rtl/cms_div.sv
`timescale 1ns/1ps
module cms_div #(
  parameter int HW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [HW-1:0] half_i,
  output logic          div_o
);
  localparam logic [HW-1:0] ONE = HW'(1);

  logic [HW-1:0] cnt_q;
  logic          div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (cnt_q == half_i - ONE) begin
      cnt_q <= '0;
      div_q <= ~div_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/cms_branch.sv
`timescale 1ns/1ps
// Enable for one clock source; resynchronised on the source's own falling edge
module cms_branch #(
  parameter int STAGES = 2,
  parameter bit RST_ON = 1'b0
) (
  input  logic src_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic en_o,
  output logic clk_o
);
  logic [STAGES-1:0] stg_q;

  always_ff @(negedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_ON}};
    else         stg_q <= {stg_q[STAGES-2:0], req_i};
  end

  assign en_o  = stg_q[STAGES-1];
  assign clk_o = src_clk_i & en_o;
endmodule

// File: rtl/cms_sync.sv
`timescale 1ns/1ps
module cms_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cms_ctrl.sv
`timescale 1ns/1ps
module cms_ctrl
  import clk_mode_pkg::*;
#(
  parameter int HW        = 3,
  parameter int MID_HALF  = 4,
  parameter int HIGH_HALF = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  mode_e            wr_mode_i,
  input  logic             wr_clr_i,
  input  logic [N_SRC-1:0] en_s_i,
  output logic [N_SRC-1:0] sel_o,
  output logic             div_clr_o,
  output logic [HW-1:0]    half_o,
  output mode_e            mode_o,
  output logic             busy_o,
  output logic             err_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_OFF, ST_ON} st_e;

  st_e              st_q;
  mode_e            mode_q, tgt_q, pend_q;
  logic             pend_v_q, err_q;
  logic [N_SRC-1:0] sel_q;
  logic [HW-1:0]    half_q;
  logic             all_off;

  assign all_off = (en_s_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      mode_q   <= MODE_MID;
      tgt_q    <= MODE_MID;
      pend_q   <= MODE_MID;
      pend_v_q <= 1'b0;
      err_q    <= 1'b0;
      sel_q    <= src_of(MODE_MID);
      half_q   <= HW'(MID_HALF);
    end else begin
      if (wr_en_i) begin
        pend_v_q <= 1'b1;
        pend_q   <= wr_mode_i;
        if (wr_clr_i) err_q <= 1'b0;
      end
      case (st_q)
        ST_IDLE: begin
          if (pend_v_q) begin
            if (!wr_en_i) pend_v_q <= 1'b0;
            if (step_refused(mode_q, pend_q)) begin
              err_q <= 1'b1;
            end else if (pend_q != mode_q) begin
              tgt_q <= pend_q;
              sel_q <= '0;
              st_q  <= ST_OFF;
            end
          end
        end
        ST_OFF: begin
          if (all_off) begin
            sel_q  <= src_of(tgt_q);
            half_q <= (tgt_q == MODE_HIGH) ? HW'(HIGH_HALF) : HW'(MID_HALF);
            st_q   <= ST_ON;
          end
        end
        ST_ON: begin
          if ((en_s_i & sel_q) != '0) begin
            mode_q <= tgt_q;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // divider restarts only after every enable is seen off
  assign div_clr_o = (st_q == ST_OFF) && all_off;
  assign sel_o     = sel_q;
  assign half_o    = half_q;
  assign mode_o    = mode_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign err_o     = err_q;
endmodule

// File: rtl/clk_mode_switch.sv
`timescale 1ns/1ps
module clk_mode_switch
  import clk_mode_pkg::*;
#(
  parameter int MID_DIV     = 8,
  parameter int HIGH_DIV    = 2,
  parameter int LOW_DIV     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_main_i,
  input  logic       clk_sub_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_data_i,
  output logic [1:0] mode_o,
  output logic       busy_o,
  output logic       err_o,
  output logic       phi_o
);
  localparam int MID_HALF  = MID_DIV / 2;
  localparam int HIGH_HALF = HIGH_DIV / 2;
  localparam int LOW_HALF  = LOW_DIV / 2;
  localparam int MAX_HALF  = (MID_HALF > HIGH_HALF) ? MID_HALF : HIGH_HALF;
  localparam int HW        = $clog2(MAX_HALF + 1);
  localparam int LHW       = $clog2(LOW_HALF + 1);

  logic [N_SRC-1:0] sel, en_raw, en_s, src_clk, gclk;
  logic             div_clr, div_main, div_sub;
  logic [HW-1:0]    half;
  mode_e            mode;

  cms_ctrl #(
    .HW(HW), .MID_HALF(MID_HALF), .HIGH_HALF(HIGH_HALF)
  ) u_ctrl (
    .clk_i     (clk_main_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_mode_i (mode_e'(wr_data_i[1:0])),
    .wr_clr_i  (wr_data_i[2]),
    .en_s_i    (en_s),
    .sel_o     (sel),
    .div_clr_o (div_clr),
    .half_o    (half),
    .mode_o    (mode),
    .busy_o    (busy_o),
    .err_o     (err_o)
  );

  cms_div #(.HW(HW)) u_div_main (
    .clk_i (clk_main_i), .rst_ni(rst_ni), .clr_i(div_clr),
    .half_i(half), .div_o(div_main)
  );

  cms_div #(.HW(LHW)) u_div_sub (
    .clk_i (clk_sub_i), .rst_ni(rst_ni), .clr_i(1'b0),
    .half_i(LHW'(LOW_HALF)), .div_o(div_sub)
  );

  assign src_clk[SRC_RAW] = clk_main_i;
  assign src_clk[SRC_DIV] = div_main;
  assign src_clk[SRC_SUB] = div_sub;

  for (genvar k = 0; k < N_SRC; k++) begin : g_br
    cms_branch #(
      .STAGES(SYNC_STAGES), .RST_ON(k == SRC_DIV)
    ) u_br (
      .src_clk_i(src_clk[k]), .rst_ni(rst_ni), .req_i(sel[k]),
      .en_o(en_raw[k]), .clk_o(gclk[k])
    );
  end

  cms_sync #(
    .W(N_SRC), .STAGES(SYNC_STAGES), .RST_VAL(src_of(MODE_MID))
  ) u_en_sync (
    .clk_i(clk_main_i), .rst_ni(rst_ni), .d_i(en_raw), .q_o(en_s)
  );

  assign phi_o  = |gclk;
  assign mode_o = mode;
endmodule

// File: rtl/clk_mode_switch_chk.sv
`timescale 1ns/1ps
module clk_mode_switch_chk
  import clk_mode_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             busy_i,
  input logic             err_i,
  input logic             wr_en_i,
  input logic             wr_clr_i,
  input logic [N_SRC-1:0] en_i,
  input logic [N_SRC-1:0] sel_i
);
  a_r10_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_i));

  a_r6_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_i) |-> $stable(mode_i));

  a_r4_no_low_dbl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_i) == 2'b00) |-> (mode_i != 2'b11));

  a_r5_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_i) && !($past(wr_en_i) && $past(wr_clr_i))) |-> err_i);

  a_r6_done_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ((en_i & src_of(mode_e'(mode_i))) != '0));

  a_r6_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (sel_i == src_of(mode_e'(mode_i))));
endmodule

bind clk_mode_switch clk_mode_switch_chk u_chk (
  .clk_i   (clk_main_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_o),
  .busy_i  (busy_o),
  .err_i   (err_o),
  .wr_en_i (wr_en_i),
  .wr_clr_i(wr_data_i[2]),
  .en_i    (en_raw),
  .sel_i   (sel)
);

// File: tb/clk_mode_switch_bench.sv
`timescale 1ns/1ps
module clk_mode_switch_bench;
  localparam real T_MAIN = 5.0;
  localparam real T_SUB  = 62.0;
  localparam real T_LOW  = 2.0 * T_SUB;

  logic       clk_main = 1'b0, clk_sub = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_data = 3'b0;
  logic [1:0] mode;
  logic       busy, err, phi;

  int  n_run = 0, n_fail = 0;
  bool_t_dummy_none dummy_unused();

  always #2.5 clk_main = ~clk_main;
  always #31  clk_sub  = ~clk_sub;

  clk_mode_switch u_clk_mode_switch (
    .clk_main_i(clk_main), .clk_sub_i(clk_sub), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .mode_o(mode), .busy_o(busy), .err_o(err), .phi_o(phi)
  );

  // R10: pulse-width monitor on phi
  bit  mon_on = 1'b0;
  real last_edge = 0.0;
  real min_width = 1.0e9;
  always @(phi) begin
    if (mon_on) begin
      if ($realtime - last_edge < min_width) min_width = $realtime - last_edge;
    end
    last_edge = $realtime;
  end

  task automatic check(input string req, input bit ok, input string msg);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic wr(input logic [2:0] d);
    @(negedge clk_main);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk_main);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    repeat (3) @(negedge clk_main);
    while (busy) @(negedge clk_main);
  endtask

  function automatic real exp_period(input logic [1:0] m);
    case (m)
      2'b00:   return T_LOW;
      2'b01:   return 8.0 * T_MAIN;
      2'b10:   return 2.0 * T_MAIN;
      default: return T_MAIN;
    endcase
  endfunction

  task automatic chk_period(input string req, input logic [1:0] m);
    real t0, p;
    repeat (2) @(posedge phi);
    t0 = $realtime;
    @(posedge phi);
    p = $realtime - t0;
    check(req, (p > exp_period(m) - 0.01) && (p < exp_period(m) + 0.01),
          $sformatf("mode %0d period act %0.2f exp %0.2f", m, p, exp_period(m)));
  endtask

  task automatic go_to(input logic [1:0] m);
    if (mode == m) return;
    if (mode == 2'b00 && m == 2'b11) begin
      wr({1'b0, 2'b01});
      wait_done();
    end
    wr({1'b0, m});
    wait_done();
  endtask

  initial begin
    real t0, dt;
    repeat (3) @(negedge clk_main);
    rst_n = 1'b1;
    @(negedge clk_main);
    mon_on = 1'b1;

    // R1 reset state
    check("R1", mode == 2'b01, $sformatf("mode act %0d exp 1", mode));
    check("R1", busy == 1'b0,  $sformatf("busy act %0b exp 0", busy));
    check("R1", err == 1'b0,   $sformatf("err act %0b exp 0", err));
    chk_period("R1", 2'b01);

    // R9 same-mode write
    wr(3'b001);
    repeat (4) begin
      @(negedge clk_main);
      check("R9", busy == 1'b0, $sformatf("busy act %0b exp 0", busy));
    end
    chk_period("R9", 2'b01);

    // R2/R3/R4/R6 sweep over every (from, to) pair
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        go_to(2'(f));
        if (err) begin wr({1'b1, mode}); wait_done(); end
        wr({1'b0, 2'(t)});
        wait_done();
        if (f == 0 && t == 3) begin
          check("R4", mode == 2'b00, $sformatf("mode act %0d exp 0", mode));
          check("R4", err == 1'b1,   $sformatf("err act %0b exp 1", err));
          chk_period("R4", 2'b00);
        end else begin
          check("R6", mode == 2'(t), $sformatf("from %0d mode act %0d exp %0d", f, mode, t));
          check("R2", err == 1'b0,   $sformatf("err act %0b exp 0", err));
          chk_period("R3", 2'(t));
        end
      end
    end

    // R5 sticky error
    go_to(2'b00);
    wr(3'b011);
    wait_done();
    check("R5", err == 1'b1, $sformatf("err act %0b exp 1", err));
    wr(3'b000);
    wait_done();
    check("R5", err == 1'b1, $sformatf("err after plain write act %0b exp 1", err));
    wr(3'b100);
    wait_done();
    check("R5", err == 1'b0, $sformatf("err after clear act %0b exp 0", err));

    // R7 leaving low-speed: 1..4 low periods
    for (int t = 1; t < 3; t++) begin
      go_to(2'b00);
      repeat (2) @(posedge phi);
      @(negedge clk_main);
      t0 = $realtime;
      wr_en = 1'b1; wr_data = {1'b0, 2'(t)};
      @(negedge clk_main);
      wr_en = 1'b0;
      wait_done();
      dt = $realtime - t0;
      check("R7", (dt >= T_LOW) && (dt <= 4.0 * T_LOW),
            $sformatf("leave time act %0.1f exp %0.1f..%0.1f", dt, T_LOW, 4.0 * T_LOW));
      check("R7", mode == 2'(t), $sformatf("mode act %0d exp %0d", mode, t));
    end

    // R8 hold-off; last held write wins
    go_to(2'b10);
    wr(3'b001);
    while (!busy) @(negedge clk_main);
    wr(3'b000);
    wr(3'b011);
    @(negedge busy);
    #1;
    check("R8", mode == 2'b01, $sformatf("first done mode act %0d exp 1", mode));
    wait_done();
    check("R8", mode == 2'b11, $sformatf("final mode act %0d exp 3", mode));
    check("R8", err == 1'b0,   $sformatf("err act %0b exp 0", err));
    chk_period("R8", 2'b11);

    // R10 no short phase seen anywhere above
    check("R10", min_width > 0.5 * T_MAIN - 0.01,
          $sformatf("min phase act %0.2f exp >= %0.2f", min_width, 0.5 * T_MAIN));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #900000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, act hung exp done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule

module bool_t_dummy_none;
endmodule